// File: doc/BRIEF.md
# Predicted-Ray Warp Collector

The collector sits after the intersection predictor and gathers the identifiers of rays that were given a prediction. These rays then form fresh traversal warps. In any cycle one source warp can offer up to 32 lanes, and any subset of those lanes may be valid. Only the ray IDs are kept, because every other ray attribute lives in a separate ray store that is addressed by ID. Accepted IDs go into a 64-entry circular store. The valid lanes are packed without gaps, in ascending lane order, and behind everything already held.

Whenever 32 or more IDs are held, the collector offers a complete 32-lane warp built from the oldest entries. Any surplus stays in the store for the next group. When rays arrive too slowly, a 5-bit wait counter releases a short group once it reaches a programmable threshold. Each output group is a lane mask plus IDs, packed into the low lanes, and it leaves through a valid/ready handshake. The input side also uses valid/ready, and it is held back when a beat would not fit.

Top module: `ray_warp_collector`

## Requirements
- R1: After reset the store is empty, `out_valid_o` is 0 and `in_ready_o` is 1. An empty store never offers a group.
- R2: Valid input lanes are stored in ascending lane order, behind earlier beats. The output places the oldest IDs from lane 0 upward, and the output mask is set exactly for lanes 0..n-1.
- R3: The store never holds more than 64 IDs. An input beat that is refused leaves no trace in the groups that follow.
- R4: In the cycle after the held count reaches 32 or more, `out_valid_o` is 1 with all 32 mask bits set. Entries beyond the emitted 32 remain for later groups.
- R5: When the store holds between 1 and 31 IDs, a group holding all of them is offered once the wait counter reaches the threshold. The counter stays at 0 through the cycle in which the first ID enters an empty store. It then advances by one per clock, so `out_valid_o` rises exactly T clocks after that arrival edge.
- R6: The threshold T is `tmo_limit_i` clamped to the range 5..30. A value below 5 acts as 5, and a value above 30 acts as 30.
- R7: Every emitted group resets the wait counter to 0. Entries left behind wait another T clocks before a timeout release.
- R8: `in_ready_o` is 1 exactly when the number of set bits in `in_mask_i` does not exceed the free space. Free space is 64 minus the held count, plus the size of the group leaving in the same cycle.
- R9: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_valid_o` stays 1 and the IDs already on the low lanes do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmo_limit_i | input | 5 | Wait threshold in clocks (clamped 5..30) |
| in_valid_i | input | 1 | Input beat present |
| in_ready_o | output | 1 | Input beat fits and will be taken |
| in_mask_i | input | 32 | Per-lane valid bits of the input beat |
| in_ids_i | input | 384 | Ray ID per input lane, lane k at bits [12k+11:12k] |
| out_valid_o | output | 1 | A group is offered |
| out_ready_i | input | 1 | Consumer takes the offered group |
| out_mask_o | output | 32 | Occupied lanes of the offered group |
| out_ids_o | output | 384 | Ray ID per output lane, unused lanes zero |

## Verification
An accepted beat changes the held count at the clock edge that takes it. A full group is therefore visible one clock after that edge, and a timeout group appears exactly T edges after the arrival edge, or T edges after the emission that left entries behind. The bench drives inputs and samples outputs on falling edges. It counts rising edges from the relevant event, and it checks both that `out_valid_o` is still low one clock before the due cycle and that it is high in that cycle. `in_ready_o` is combinational, so it is checked in the same half cycle as the stimulus, before and after `out_ready_i` is raised.

// File: rtl/rwc_pkg.sv
package rwc_pkg;
  localparam int unsigned TMO_W   = 5;
  localparam int unsigned TMO_MIN = 5;
  localparam int unsigned TMO_MAX = 30;

  function automatic logic [TMO_W-1:0] clamp_limit(input logic [TMO_W-1:0] lim);
    if (lim < TMO_W'(TMO_MIN)) return TMO_W'(TMO_MIN);
    if (lim > TMO_W'(TMO_MAX)) return TMO_W'(TMO_MAX);
    return lim;
  endfunction
endpackage

// File: rtl/rwc_compact.sv
module rwc_compact #(
  parameter int unsigned LANES = 32,
  parameter int unsigned ID_W  = 12,
  localparam int unsigned NW    = $clog2(LANES + 1),
  localparam int unsigned IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0]            mask_i,
  input  logic [LANES*ID_W-1:0]       ids_i,
  output logic [LANES-1:0][ID_W-1:0]  ids_o,
  output logic [NW-1:0]               num_o
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    ids_o = '0;
    idx   = '0;
    for (int i = 0; i < LANES; i++) begin
      if (mask_i[i]) begin
        ids_o[idx] = ids_i[i*ID_W +: ID_W];
        idx        = idx + 1'b1;
      end
    end
  end

  assign num_o = NW'($countones(mask_i));
endmodule

// File: rtl/rwc_store.sv
module rwc_store #(
  parameter int unsigned LANES = 32,
  parameter int unsigned ID_W  = 12,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned NW    = $clog2(LANES + 1),
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        push_i,
  input  logic [NW-1:0]               push_num_i,
  input  logic [LANES-1:0][ID_W-1:0]  push_ids_i,
  input  logic                        pop_i,
  input  logic [NW-1:0]               pop_num_i,
  output logic [CNT_W-1:0]            count_o,
  output logic [LANES-1:0][ID_W-1:0]  head_o
);
  logic [DEPTH-1:0][ID_W-1:0] mem_q;
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic [NW-1:0]    add_n, sub_n;

  assign add_n = push_i ? push_num_i : '0;
  assign sub_n = pop_i  ? pop_num_i  : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + PTR_W'(add_n);
      rd_ptr_q <= rd_ptr_q + PTR_W'(sub_n);
      count_q  <= count_q + CNT_W'(add_n) - CNT_W'(sub_n);
    end
  end

  always_ff @(posedge clk_i) begin
    for (int j = 0; j < LANES; j++) begin
      if (push_i && (NW'(j) < push_num_i))
        mem_q[wr_ptr_q + PTR_W'(j)] <= push_ids_i[j];
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) head_o[k] = mem_q[rd_ptr_q + PTR_W'(k)];
  end

  assign count_o = count_q;

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));

  p_ptr_span_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    PTR_W'(wr_ptr_q - rd_ptr_q) == count_q[PTR_W-1:0]);
endmodule

// File: rtl/rwc_timer.sv
module rwc_timer
  import rwc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             held_i,
  input  logic             pop_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] tmr_q, lim;

  assign lim = clamp_limit(limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  tmr_q <= '0;
    else if (pop_i || !held_i)    tmr_q <= '0;
    else if (tmr_q != '1)         tmr_q <= tmr_q + 1'b1;
  end

  assign expired_o = held_i && (tmr_q >= lim);

  p_timer_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> (tmr_q == '0));

  p_timer_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_i && tmr_q < TMO_W'(TMO_MIN)) |-> !expired_o);
endmodule

// File: rtl/ray_warp_collector.sv
module ray_warp_collector
  import rwc_pkg::*;
#(
  parameter int unsigned LANES = 32,
  parameter int unsigned ID_W  = 12,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned NW    = $clog2(LANES + 1),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [TMO_W-1:0]      tmo_limit_i,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  input  logic [LANES-1:0]      in_mask_i,
  input  logic [LANES*ID_W-1:0] in_ids_i,
  output logic                  out_valid_o,
  input  logic                  out_ready_i,
  output logic [LANES-1:0]      out_mask_o,
  output logic [LANES*ID_W-1:0] out_ids_o
);
  logic [LANES-1:0][ID_W-1:0] comp_ids, head_ids;
  logic [NW-1:0]    push_n, out_n;
  logic [CNT_W-1:0] count, free_n;
  logic             push, pop, expired, full_grp;

  rwc_compact #(.LANES(LANES), .ID_W(ID_W)) u_compact (
    .mask_i (in_mask_i),
    .ids_i  (in_ids_i),
    .ids_o  (comp_ids),
    .num_o  (push_n)
  );

  rwc_store #(.LANES(LANES), .ID_W(ID_W), .DEPTH(DEPTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_num_i (push_n),
    .push_ids_i (comp_ids),
    .pop_i      (pop),
    .pop_num_i  (out_n),
    .count_o    (count),
    .head_o     (head_ids)
  );

  rwc_timer u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .held_i    (count != '0),
    .pop_i     (pop),
    .limit_i   (tmo_limit_i),
    .expired_o (expired)
  );

  assign full_grp    = count >= CNT_W'(LANES);
  assign out_n       = full_grp ? NW'(LANES) : NW'(count);
  assign out_valid_o = full_grp || expired;
  assign pop         = out_valid_o && out_ready_i;

  // space freed by a same-cycle emission counts toward acceptance
  assign free_n     = CNT_W'(DEPTH) - count + (pop ? CNT_W'(out_n) : '0);
  assign in_ready_o = CNT_W'(push_n) <= free_n;
  assign push       = in_valid_i && in_ready_o;

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      out_mask_o[k]              = NW'(k) < out_n;
      out_ids_o[k*ID_W +: ID_W]  = (NW'(k) < out_n) ? head_ids[k] : '0;
    end
  end

  p_empty_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count == '0) |-> !out_valid_o);

  p_full_offer_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_grp |-> (out_valid_o && out_mask_o == '1));

  p_stall_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o);

  p_refuse_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count == CNT_W'(DEPTH) && !out_ready_i && in_mask_i != '0) |-> !in_ready_o);
endmodule

// File: tb/ray_warp_collector_tb.sv
module ray_warp_collector_tb;
  localparam int LANES = 32;
  localparam int ID_W  = 12;

  logic                  clk = 1'b0;
  logic                  rst_ni = 1'b0;
  logic [4:0]            tmo_limit = 5'd5;
  logic                  in_valid = 1'b0;
  logic                  in_ready;
  logic [LANES-1:0]      in_mask = '0;
  logic [LANES*ID_W-1:0] in_ids = '0;
  logic                  out_valid;
  logic                  out_ready = 1'b0;
  logic [LANES-1:0]      out_mask;
  logic [LANES*ID_W-1:0] out_ids;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ray_warp_collector u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .tmo_limit_i (tmo_limit),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_mask_i   (in_mask),
    .in_ids_i    (in_ids),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_mask_o  (out_mask),
    .out_ids_o   (out_ids)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lane_id(input int k);
    return int'(out_ids[k*ID_W +: ID_W]);
  endfunction

  task automatic set_beat(input logic [LANES-1:0] m, input int base);
    in_mask = m;
    for (int l = 0; l < LANES; l++) in_ids[l*ID_W +: ID_W] = ID_W'(base + l);
  endtask

  // returns at the falling edge right after the accepting rising edge
  task automatic push(input logic [LANES-1:0] m, input int base);
    @(negedge clk);
    set_beat(m, base);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    in_mask  = '0;
  endtask

  task automatic pop_one();
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  // checks out_valid stays low until exactly `due` edges have passed
  task automatic wait_release(input string req, input int due);
    for (int k = 1; k <= due; k++) begin
      @(negedge clk);
      if (k >= due - 1) chk(req, out_valid, (k == due));
    end
  endtask

  task automatic t_reset();
    chk("R1 valid after reset", out_valid, 0);
    chk("R1 ready after reset", in_ready, 1);
  endtask

  task automatic t_compact_timeout();
    tmo_limit = 5'd5;
    push(32'h0000_00A5, 100);
    chk("R1 no offer below threshold", out_valid, 0);
    wait_release("R5 timeout release", 5);
    chk("R2 mask", out_mask, 32'h0000_000F);
    chk("R2 lane0", lane_id(0), 100);
    chk("R2 lane1", lane_id(1), 102);
    chk("R2 lane2", lane_id(2), 105);
    chk("R2 lane3", lane_id(3), 107);
    pop_one();
    chk("R1 empty after drain", out_valid, 0);
  endtask

  task automatic t_full_group();
    tmo_limit = 5'd7;
    out_ready = 1'b0;
    push(32'h3FFF_FFFF, 200);
    push(32'h0000_7FFF, 300);
    chk("R4 full offer", out_valid, 1);
    chk("R4 full mask", out_mask, 32'hFFFF_FFFF);
    chk("R4 lane29", lane_id(29), 229);
    chk("R4 lane30", lane_id(30), 300);
    chk("R4 lane31", lane_id(31), 301);
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      chk("R9 stall valid", out_valid, 1);
      chk("R9 stall lane0", lane_id(0), 200);
    end
    pop_one();
    chk("R7 restart after emission", out_valid, 0);
    wait_release("R7 leftover timeout", 7);
    chk("R4 leftover mask", out_mask, 32'h0000_1FFF);
    chk("R4 leftover lane0", lane_id(0), 302);
    chk("R4 leftover lane12", lane_id(12), 314);
    pop_one();
  endtask

  task automatic t_clamp();
    tmo_limit = 5'd2;
    push(32'h8000_0000, 900);
    wait_release("R6 low clamp", 5);
    chk("R6 low clamp mask", out_mask, 1);
    chk("R6 low clamp id", lane_id(0), 931);
    pop_one();
    tmo_limit = 5'd31;
    push(32'h0000_0001, 950);
    wait_release("R6 high clamp", 30);
    pop_one();
  endtask

  task automatic t_capacity();
    tmo_limit = 5'd30;
    out_ready = 1'b0;
    push(32'hFFFF_FFFF, 400);
    push(32'hFFFF_FFFF, 500);
    @(negedge clk);
    set_beat(32'h0000_0001, 700);
    in_valid = 1'b1;
    #1 chk("R8 refuse when full", in_ready, 0);
    @(negedge clk);
    set_beat(32'hFFFF_FFFF, 600);
    #1 chk("R8 refuse full beat", in_ready, 0);
    out_ready = 1'b1;
    #1 chk("R8 accept with emission credit", in_ready, 1);
    chk("R2 oldest group lane0", lane_id(0), 400);
    chk("R2 oldest group lane31", lane_id(31), 431);
    @(negedge clk);
    in_valid = 1'b0;
    in_mask  = '0;
    out_ready = 1'b0;
    chk("R3 second group lane0", lane_id(0), 500);
    chk("R3 second group lane31", lane_id(31), 531);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R3 third group valid", out_valid, 1);
    chk("R3 third group lane0", lane_id(0), 600);
    chk("R3 third group lane31", lane_id(31), 631);
    @(negedge clk);
    out_ready = 1'b0;
    chk("R3 refused beat left no entry", out_valid, 0);
    chk("R3 ready when empty", in_ready, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_compact_timeout();
    t_full_group();
    t_clamp();
    t_capacity();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule